// File: doc/BRIEF.md
# Soft Reset Control Register Bank

This block is a small bank of 32-bit control registers whose bits drive individual active-high reset lines into on-chip peripherals. Software reaches the registers over a plain register bus made of a byte address, write data, a write strobe and a combinational read-data return. The register at index i sits at byte address 4*i. The block exposes every reset line as one flat output vector indexed by reset ID.

A build-time parameter selects between two register layouts. In masked layout each register carries 16 reset lines. The upper half of each write word is a per-bit enable for the lower half, so one write can set or clear a single line without first reading the register. In plain layout each register carries 32 reset lines, and a write replaces all of them. Changing one line in plain layout therefore takes a read, a bit change and a write back.

The bus has no handshake. A write completes on the clock edge where the strobe is high, and a read returns data in the same cycle. No back-pressure exists, and the bus never stalls.

Top module: `srst_bank`

## Requirements
- R1: While the active-low hardware reset is low, every reset output is 0 and every register reads as 0.
- R2: The register index is address bits [ADDR_W-1:2]. Address bits [1:0] are ignored, so register i answers at byte addresses 4*i through 4*i+3.
- R3: In masked layout, a write with bit k and bit k+16 both set (k in 0..15) makes line k of the addressed register 1.
- R4: In masked layout, a write with bit k+16 set and bit k clear makes line k of the addressed register 0.
- R5: In masked layout, a line k whose enable bit k+16 is 0 in the write keeps its previous value.
- R6: In masked layout, a read returns the 16 line states in bits [15:0] and 0 in bits [31:16].
- R7: In plain layout, a write replaces all 32 lines of the addressed register with the write data, and a read returns those 32 bits.
- R8: Reset ID n drives output bit n, which equals bit (n mod L) of register (n div L). L is 16 in masked layout and 32 in plain layout, and the output width is NUM_REGS*L.
- R9: A write to a register index at or above NUM_REGS changes nothing, and a read of such an index returns 0.
- R10: A write takes effect at the clock edge where the write strobe is high. Outputs do not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Read data for addr, combinational |
| rst_o | output | NUM_REGS*L | Reset lines, bit n is reset ID n |

## Verification
On every cycle the bound checker confirms several properties. Outputs hold still without a valid write. Read data for an out-of-range index is zero. Masked reads carry a zero upper half and agree with the matching output slice. After each accepted write, the changed register holds exactly what the masked or plain rule predicts, and unenabled lines are left as they were. The bench covers what needs a chosen sequence: the cleared state during reset, the aliasing of the low address bits, single-line set and clear at chosen reset IDs, and writes beyond the last register. Long random write mixes in both layouts are compared against a bench model.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef logic [31:0] word_t;

  function automatic int lines_per_reg(input bit masked);
    return masked ? 16 : 32;
  endfunction
endpackage

// File: rtl/srst_dec.sv
module srst_dec #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit,
  output logic                in_range
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0] NREG_V = (IDX_W+1)'(NUM_REGS);

  logic [IDX_W-1:0] idx;
  assign idx      = addr[ADDR_W-1:2];
  assign in_range = ({1'b0, idx} < NREG_V);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = in_range && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/srst_cell.sv
module srst_cell
  import srst_pkg::*;
#(
  parameter bit MASKED = 1'b1,
  localparam int L = lines_per_reg(MASKED)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  word_t        wdata,
  output logic [L-1:0] q
);
  logic [L-1:0] nxt;

  if (MASKED) begin : g_masked
    assign nxt = (q & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
  end else begin : g_plain
    assign nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/srst_rdmux.sv
module srst_rdmux
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int L        = 16
) (
  input  logic [NUM_REGS-1:0]   hit,
  input  logic [NUM_REGS*L-1:0] flat,
  output word_t                 rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rdata[L-1:0] = flat[i*L +: L];
    end
  end
endmodule

// File: rtl/srst_bank.sv
module srst_bank
  import srst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter bit MASKED   = 1'b1,
  parameter int ADDR_W   = 6,
  localparam int L       = lines_per_reg(MASKED),
  localparam int NRST    = NUM_REGS * L
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  output logic [NRST-1:0]   rst_o
);
  logic [NUM_REGS-1:0] hit;
  logic                in_range;

  srst_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .hit(hit), .in_range(in_range)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [L-1:0] q;
    srst_cell #(.MASKED(MASKED)) u_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(we && hit[i]),
      .wdata(wdata), .q(q)
    );
    assign rst_o[i*L +: L] = q;
  end

  srst_rdmux #(.NUM_REGS(NUM_REGS), .L(L)) u_rd (
    .hit(hit), .flat(rst_o), .rdata(rdata)
  );
endmodule

// File: rtl/srst_bank_chk.sv
module srst_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter bit MASKED   = 1'b1,
  parameter int ADDR_W   = 6,
  localparam int L       = MASKED ? 16 : 32,
  localparam int NRST    = NUM_REGS * L,
  localparam int IDX_W   = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              we,
  input logic [31:0]       rdata,
  input logic [NRST-1:0]   rst_o
);
  logic [IDX_W-1:0] idx;
  logic             oor;
  logic [L-1:0]     cur_slice;
  assign idx = addr[ADDR_W-1:2];
  assign oor = (int'(idx) >= NUM_REGS);

  always_comb begin
    cur_slice = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(idx) == i) cur_slice = rst_o[i*L +: L];
  end

  logic             w_q;
  logic [IDX_W-1:0] w_idx;
  logic [L-1:0]     w_old;
  logic [31:0]      w_dat;
  logic [L-1:0]     now_slice;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= 1'b0; w_idx <= '0; w_old <= '0; w_dat <= '0;
    end else begin
      w_q   <= we && !oor;
      w_idx <= idx;
      w_old <= cur_slice;
      w_dat <= wdata;
    end
  end

  always_comb begin
    now_slice = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(w_idx) == i) now_slice = rst_o[i*L +: L];
  end

  // R10: no write, no change
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rst_o));

  // R9: out-of-range write ignored, read returns zero
  a_r9_oor_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && oor) |=> $stable(rst_o));
  a_r9_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (rdata == 32'd0));

  // R8: read data agrees with the output slice of the addressed register
  a_r8_read_matches_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !oor |-> (rdata[L-1:0] == cur_slice));

  if (MASKED) begin : g_m
    logic [15:0] en;
    assign en = w_dat[31:16];
    // R6: upper half of a read is zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[31:16] == 16'd0);
    // R3 R4: enabled lines take the written value
    a_r3_enabled_take_data: assert property (@(posedge clk) disable iff (!rst_n)
      w_q |-> ((now_slice & en) == (w_dat[15:0] & en)));
    // R5: unenabled lines keep their value
    a_r5_unenabled_keep: assert property (@(posedge clk) disable iff (!rst_n)
      w_q |-> (((now_slice ^ w_old) & ~en) == 16'd0));
  end else begin : g_p
    // R7: plain write replaces the register
    a_r7_plain_replace: assert property (@(posedge clk) disable iff (!rst_n)
      w_q |-> (now_slice == w_dat));
  end
endmodule

bind srst_bank srst_bank_chk #(.NUM_REGS(NUM_REGS), .MASKED(MASKED), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .rdata(rdata), .rst_o(rst_o)
);

// File: tb/sim_srst_bank.sv
module sim_srst_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we_m = 1'b0, we_p = 1'b0;
  logic [31:0] rdata_m, rdata_p;
  logic [63:0] rst_m;
  logic [95:0] rst_p;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [15:0] em[4];
  logic [31:0] ep[3];

  always #4 clk = ~clk;

  srst_bank #(.NUM_REGS(4), .MASKED(1'b1), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we_m),
    .rdata(rdata_m), .rst_o(rst_m));

  srst_bank #(.NUM_REGS(3), .MASKED(1'b0), .ADDR_W(6)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we_p),
    .rdata(rdata_p), .rst_o(rst_p));

  function automatic logic [95:0] vec_m();
    logic [95:0] v = '0;
    for (int n = 0; n < 64; n++) v[n] = em[n/16][n%16];
    return v;
  endfunction

  function automatic logic [95:0] vec_p();
    logic [95:0] v = '0;
    for (int n = 0; n < 96; n++) v[n] = ep[n/32][n%32];
    return v;
  endfunction

  function automatic logic [31:0] rd_m(input int idx);
    return (idx < 4) ? {16'h0, em[idx]} : 32'h0;
  endfunction

  function automatic logic [31:0] rd_p(input int idx);
    return (idx < 3) ? ep[idx] : 32'h0;
  endfunction

  function automatic logic [15:0] mask_apply(input logic [15:0] o, input logic [31:0] d);
    return (o & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " masked lines"}, {32'h0, rst_m}, vec_m());
    chk({tag, " plain lines"}, rst_p, vec_p());
  endtask

  task automatic wr(input bit plain, input logic [5:0] a, input logic [31:0] d);
    int idx;
    @(negedge clk);
    addr = a; wdata = d; we_m = !plain; we_p = plain;
    #1 check_outs("R10 before edge");
    @(negedge clk);
    we_m = 1'b0; we_p = 1'b0;
    idx = int'(a[5:2]);
    if (plain) begin
      if (idx < 3) ep[idx] = d;
    end else begin
      if (idx < 4) em[idx] = mask_apply(em[idx], d);
    end
  endtask

  task automatic rd(input string tag, input logic [5:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk({tag, " masked read"}, {64'h0, rdata_m}, {64'h0, rd_m(int'(a[5:2]))});
    chk({tag, " plain read"},  {64'h0, rdata_p}, {64'h0, rd_p(int'(a[5:2]))});
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) rd(tag, 6'(i*4 + (i % 4)));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) em[i] = '0;
    for (int i = 0; i < 3; i++) ep[i] = '0;

    // R1: cleared during reset, even with a write strobe high
    repeat (3) @(negedge clk);
    addr = 6'd4; wdata = 32'hFFFF_FFFF; we_m = 1'b1; we_p = 1'b1;
    @(negedge clk);
    we_m = 1'b0; we_p = 1'b0;
    check_outs("R1 in reset");
    for (int i = 0; i < 4; i++) begin
      addr = 6'(i*4); #1;
      chk("R1 read in reset", {64'h0, rdata_m, rdata_p}, 96'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    check_outs("R1 after release");

    // R3: reset ID 16 (reg 1 bit 0), then R4 clears it
    wr(0, 6'd4, 32'h0001_0001);
    chk("R3 id16 set", {95'h0, rst_m[16]}, 96'h1);
    check_outs("R3");
    wr(0, 6'd4, 32'h0001_0000);
    chk("R4 id16 clear", {95'h0, rst_m[16]}, 96'h0);
    // R8: reset ID 37 = reg 2 bit 5
    wr(0, 6'd8, 32'h0020_0020);
    chk("R8 id37 masked", {95'h0, rst_m[37]}, 96'h1);
    // R5: enables all zero, data all ones => nothing changes
    wr(0, 6'd8, 32'h0000_FFFF);
    check_outs("R5 zero enable");
    chk("R5 id37 kept", {95'h0, rst_m[37]}, 96'h1);
    // R6: fill reg 3 and read upper half zero
    wr(0, 6'd12, 32'hFFFF_FFFF);
    rd("R6", 6'd12);
    // R2: low address bits ignored
    wr(0, 6'd11, 32'h8000_8000);
    chk("R2 alias to reg2 bit15 (id47)", {95'h0, rst_m[47]}, 96'h1);
    rd("R2 alias read", 6'd9);
    // R7: plain replace
    wr(1, 6'd0, 32'hDEAD_BEEF);
    check_outs("R7 full write");
    wr(1, 6'd0, 32'h0000_0001);
    check_outs("R7 overwrite");
    rd("R7", 6'd0);
    // R8: plain ID 70 = reg 2 bit 6
    wr(1, 6'd8, 32'h0000_0040);
    chk("R8 id70 plain", {95'h0, rst_p[70]}, 96'h1);
    // R9: out of range writes and reads
    wr(0, 6'd40, 32'hFFFF_FFFF);
    wr(1, 6'd12, 32'hFFFF_FFFF);
    wr(1, 6'd60, 32'hFFFF_FFFF);
    check_outs("R9 oor write");
    rd("R9 oor read", 6'd40);
    rd("R9 oor read", 6'd63);
    sweep("R2/R9 sweep");

    // Random mix, with single-bit set/clear in masked layout
    for (int it = 0; it < 600; it++) begin
      a = 6'($urandom % 64);
      case ($urandom % 4)
        0: begin
          int k = int'($urandom % 16);
          d = (32'h1 << (k + 16)) | (($urandom % 2) != 0 ? (32'h1 << k) : 32'h0);
        end
        default: d = $urandom;
      endcase
      wr(($urandom % 2) != 0, a, d);
      check_outs("R3/R4/R5/R7/R8 random");
      rd("R6/R7 random read", a);
      if (it % 100 == 99) sweep("R9 random sweep");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule